// File: doc/BRIEF.md
# Packed Saturating Narrowing Pack Unit

This block turns two 64-bit packed operands, called the destination and the source, into one 64-bit packed result whose lanes are half as wide as the input lanes. Each input lane is clamped to the range of the narrower output lane on its own. No lane's carry or sign reaches a neighbouring lane. Three conversions are offered: signed 32-bit to signed 16-bit, signed 16-bit to signed 8-bit, and signed 16-bit to unsigned 8-bit.

The caller presents both operands and a 2-bit mode, then pulses `start_i` for one cycle. One clock later the result, a per-lane mask of the lanes that were clamped, and an illegal-mode flag appear on registered outputs, and `done_o` pulses for one cycle. The outputs hold their values until the next start. The narrowed source always fills the upper half of the result and the narrowed destination fills the lower half, so two operands merge into one register-sized value.

Top module: `npk_pack_unit`

## Requirements
- R1: Mode 0 (signed 32 to 16 bit): an input lane below -32768 gives 16'h8000, a lane above 32767 gives 16'h7FFF, and any other lane keeps its low 16 bits in two's complement.
- R2: Mode 1 (signed 16 to 8 bit): an input lane below -128 gives 8'h80, a lane above 127 gives 8'h7F, and any other lane keeps its low 8 bits.
- R3: Mode 2 (signed 16 to unsigned 8 bit): a negative input lane gives 8'h00, a lane above 255 gives 8'hFF, and a lane from 0 to 255 passes through unchanged.
- R4: Lane order: if the input lanes are numbered from 0 at the least significant end of the 128-bit value {src_i, dst_i}, output lane k of result_o comes from input lane k. The narrowed source occupies result bits 63..32 and the narrowed destination bits 31..0, with the highest lane of each going to the highest position.
- R5: sat_mask_o bit k is 1 exactly when output lane k was clamped. In mode 0 only bits 3..0 are used and bits 7..4 read 0.
- R6: Mode 3 is reserved: it gives result_o = 0 and sat_mask_o = 0, and sets illegal_o to 1. Every other mode clears illegal_o.
- R7: done_o is 1 for exactly the one cycle after a cycle with start_i = 1. result_o, sat_mask_o and illegal_o are loaded only on a start and otherwise hold, whatever the inputs do.
- R8: While rst is high, all outputs are 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert the present operands |
| mode_i | input | 2 | 0 signed 32 to 16, 1 signed 16 to 8, 2 signed 16 to unsigned 8, 3 reserved |
| dst_i | input | 64 | Destination operand, fills the lower result half |
| src_i | input | 64 | Source operand, fills the upper result half |
| result_o | output | 64 | Registered packed result |
| sat_mask_o | output | 8 | One bit per output lane that was clamped |
| illegal_o | output | 1 | Last start used the reserved mode |
| done_o | output | 1 | Result valid pulse, one cycle after start |

## Verification
Each mode is first tried with mixed vectors in which every lane of one operand differs from every other, so a swapped half or a reversed lane order shows up as a wrong byte position. Boundary vectors then place values exactly at each limit and one step past it, in both directions, which tells a correct clamp from an off-by-one compare and shows whether a clamp that hits an in-range value still sets its mask bit. The unsigned mode is given negative and large positive inputs in the same vector, so a signed clamp used by mistake gives different bytes. Directed steps cover the reserved mode, outputs holding while the inputs change with no start, and reset during a valid result.

// File: rtl/npk_pkg.sv
package npk_pkg;

    localparam int OP_W_DEF = 64;

    typedef enum logic [1:0] {
        MD_D2W_S = 2'd0,
        MD_W2B_S = 2'd1,
        MD_W2B_U = 2'd2,
        MD_RSVD  = 2'd3
    } npk_mode_e;

    typedef struct packed {
        logic [15:0] val;
        logic        clamped;
    } half_res_t;

    typedef struct packed {
        logic [7:0] val;
        logic       clamped;
    } byte_res_t;

    function automatic half_res_t clamp_d2w(input logic [31:0] x);
        half_res_t r;
        r.clamped = !((x[31:15] == '0) || (x[31:15] == '1));
        if (r.clamped) r.val = x[31] ? 16'h8000 : 16'h7FFF;
        else           r.val = x[15:0];
        return r;
    endfunction

    function automatic byte_res_t clamp_w2b(input logic [15:0] x, input logic to_unsigned);
        byte_res_t r;
        if (to_unsigned) begin
            if (x[15]) begin
                r.clamped = 1'b1;
                r.val     = 8'h00;
            end else if (x[14:8] != '0) begin
                r.clamped = 1'b1;
                r.val     = 8'hFF;
            end else begin
                r.clamped = 1'b0;
                r.val     = x[7:0];
            end
        end else begin
            r.clamped = !((x[15:7] == '0) || (x[15:7] == '1));
            if (r.clamped) r.val = x[15] ? 8'h80 : 8'h7F;
            else           r.val = x[7:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/npk_d2w_lanes.sv
module npk_d2w_lanes #(
    parameter int OP_W = 64,
    localparam int IN_W  = 2 * OP_W,
    localparam int LANES = IN_W / 32
) (
    input  logic [IN_W-1:0]  wide_i,
    output logic [OP_W-1:0]  narrow_o,
    output logic [LANES-1:0] clamp_o
);
    import npk_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        half_res_t r;
        always_comb r = clamp_d2w(wide_i[g*32 +: 32]);
        assign narrow_o[g*16 +: 16] = r.val;
        assign clamp_o[g]           = r.clamped;
    end
endmodule

// File: rtl/npk_w2b_lanes.sv
module npk_w2b_lanes #(
    parameter int OP_W = 64,
    localparam int IN_W  = 2 * OP_W,
    localparam int LANES = IN_W / 16
) (
    input  logic [IN_W-1:0]  wide_i,
    input  logic             unsigned_i,
    output logic [OP_W-1:0]  narrow_o,
    output logic [LANES-1:0] clamp_o
);
    import npk_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_res_t r;
        always_comb r = clamp_w2b(wide_i[g*16 +: 16], unsigned_i);
        assign narrow_o[g*8 +: 8] = r.val;
        assign clamp_o[g]         = r.clamped;
    end
endmodule

// File: rtl/npk_pack_unit.sv
module npk_pack_unit #(
    parameter int OP_W = npk_pkg::OP_W_DEF,
    localparam int MASK_W = OP_W / 8,
    localparam int DW_N   = OP_W / 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [OP_W-1:0]   dst_i,
    input  logic [OP_W-1:0]   src_i,
    output logic [OP_W-1:0]   result_o,
    output logic [MASK_W-1:0] sat_mask_o,
    output logic              illegal_o,
    output logic              done_o
);
    import npk_pkg::*;

    npk_mode_e         mode;
    logic [2*OP_W-1:0] wide;
    logic [OP_W-1:0]   d2w_val, w2b_val, res_c;
    logic [DW_N-1:0]   d2w_clamp;
    logic [MASK_W-1:0] w2b_clamp, mask_c;
    logic              ill_c;

    assign mode = npk_mode_e'(mode_i);
    assign wide = {src_i, dst_i};

    npk_d2w_lanes #(.OP_W(OP_W)) i_d2w (
        .wide_i   (wide),
        .narrow_o (d2w_val),
        .clamp_o  (d2w_clamp)
    );

    npk_w2b_lanes #(.OP_W(OP_W)) i_w2b (
        .wide_i     (wide),
        .unsigned_i (mode == MD_W2B_U),
        .narrow_o   (w2b_val),
        .clamp_o    (w2b_clamp)
    );

    always_comb begin
        res_c  = '0;
        mask_c = '0;
        ill_c  = 1'b0;
        case (mode)
            MD_D2W_S: begin
                res_c  = d2w_val;
                mask_c = {{(MASK_W-DW_N){1'b0}}, d2w_clamp};
            end
            MD_W2B_S, MD_W2B_U: begin
                res_c  = w2b_val;
                mask_c = w2b_clamp;
            end
            default: ill_c = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o   <= '0;
            sat_mask_o <= '0;
            illegal_o  <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                result_o   <= res_c;
                sat_mask_o <= mask_c;
                illegal_o  <= ill_c;
            end
        end
    end
endmodule

// File: rtl/npk_pack_checker.sv
module npk_pack_checker #(
    parameter int OP_W = 64,
    localparam int MASK_W = OP_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [1:0]        mode_i,
    input logic [OP_W-1:0]   result_o,
    input logic [MASK_W-1:0] sat_mask_o,
    input logic              illegal_o,
    input logic              done_o
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o); // R7
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i)); // R7
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(result_o) && $stable(sat_mask_o) && $stable(illegal_o))); // R7
    AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == 2'd3) |=> illegal_o); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0 && sat_mask_o == '0)); // R6
    AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i != 2'd3) |=> !illegal_o); // R6
    AST_DW_MASK_UPPER: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == 2'd0) |=> (sat_mask_o[MASK_W-1:MASK_W/2] == '0)); // R5
endmodule

bind npk_pack_unit npk_pack_checker #(.OP_W(OP_W)) i_npk_pack_checker (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .result_o   (result_o),
    .sat_mask_o (sat_mask_o),
    .illegal_o  (illegal_o),
    .done_o     (done_o)
);

// File: tb/test_npk_pack_unit.sv
module test_npk_pack_unit;

    typedef struct packed {
        logic [1:0]  mode;
        logic [63:0] src;
        logic [63:0] dst;
        logic [63:0] res;
        logic [7:0]  mask;
        logic        ill;
    } vec_t;

    localparam int NV = 7;
    // R1 R2 R3 R4 R5 R6: mixed and boundary vectors per mode
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'h8000_0002_0000_8000, 64'hFFFF_8002_0000_01FC, 64'h8000_7FFF_8002_01FC, 8'h0C, 1'b0},
        '{2'd0, 64'h0000_7FFF_0000_8000, 64'hFFFF_8000_FFFF_7FFF, 64'h7FFF_7FFF_8000_8000, 8'h05, 1'b0},
        '{2'd1, 64'h007E_7F00_EF9D_FF88, 64'hFF02_0085_007E_81CF, 64'h7E7F_8088_807F_7E80, 8'h6D, 1'b0},
        '{2'd1, 64'h007F_0080_FF80_FF7F, 64'h0000_FFFF_0001_8000, 64'h7F7F_8080_00FF_0180, 8'h51, 1'b0},
        '{2'd2, 64'h0112_008B_0300_FF88, 64'h0002_023A_007E_FFF8, 64'hFF8B_FF00_02FF_7E00, 8'hB5, 1'b0},
        '{2'd2, 64'h00FF_0100_0000_FFFF, 64'h8000_7FFF_0080_0001, 64'hFFFF_0000_00FF_8001, 8'h5C, 1'b0},
        '{2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h0,                   8'h00, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] result_o;
    logic [7:0]  sat_mask_o;
    logic        illegal_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    npk_pack_unit i_npk_pack_unit (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .dst_i      (dst_i),
        .src_i      (src_i),
        .result_o   (result_o),
        .sat_mask_o (sat_mask_o),
        .illegal_o  (illegal_o),
        .done_o     (done_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [63:0] s, input logic [63:0] d);
        @(negedge clk);
        mode_i  = m;
        src_i   = s;
        dst_i   = d;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset result", result_o, 64'h0);
        chk("R8 reset mask", {56'h0, sat_mask_o}, 64'h0);
        chk("R8 reset flags", {62'h0, illegal_o, done_o}, 64'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].mode, VECS[i].src, VECS[i].dst);
            chk("R7 done pulse", {63'h0, done_o}, 64'h1);
            chk($sformatf("R1/R2/R3/R4 result vec %0d", i), result_o, VECS[i].res);
            chk($sformatf("R5 mask vec %0d", i), {56'h0, sat_mask_o}, {56'h0, VECS[i].mask});
            chk($sformatf("R6 illegal vec %0d", i), {63'h0, illegal_o}, {63'h0, VECS[i].ill});
            @(negedge clk);
            chk("R7 done single cycle", {63'h0, done_o}, 64'h0);
        end

        // R7: inputs change without start, outputs hold
        run_op(2'd1, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008);
        chk("R7 load", result_o, 64'h0102_0304_0506_0708);
        mode_i = 2'd0;
        src_i  = 64'hFFFF_FFFF_FFFF_FFFF;
        dst_i  = 64'h7777_7777_7777_7777;
        repeat (3) @(negedge clk);
        chk("R7 hold result", result_o, 64'h0102_0304_0506_0708);
        chk("R7 hold mask", {56'h0, sat_mask_o}, 64'h0);
        chk("R7 no done", {63'h0, done_o}, 64'h0);

        // R6: legal start after reserved clears flag
        run_op(2'd3, 64'h1, 64'h2);
        chk("R6 reserved flag", {63'h0, illegal_o}, 64'h1);
        run_op(2'd0, 64'h0000_0001_FFFF_FFFF, 64'h0);
        chk("R6 flag cleared", {63'h0, illegal_o}, 64'h0);
        chk("R1 small values", result_o, 64'h0001_FFFF_0000_0000);

        // R8: reset while holding a result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset clears result", result_o, 64'h0);
        chk("R8 reset clears mask", {56'h0, sat_mask_o}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule